// File: doc/BRIEF.md
# Interrupt Enable and Trap Return Control

This block keeps the processor's interrupt-enable state and the two trap vector base registers. The enable state is three bits: the live enable that gates interrupts, a copy saved when an exception is taken, and a copy saved when a debug breakpoint is taken. On entry to either kind of trap the live enable is saved into the matching copy and then cleared. A return jump restores the live enable from one of the two copies. Which copy is used depends on the register the jump goes through: register 30 means an exception return and register 31 means a breakpoint return.

Software reaches the block through control-register reads and writes. The register index comes straight out of the instruction word. Breakpoint and watchpoint register writes are only range-checked here against counts fixed at build time; the comparators that use those values live elsewhere. Every access that does not fit the register map raises a fault flag. All pins are plain control and status signals with no handshake: a request is taken on the clock edge where it is present, and its read data and fault flag come out the following cycle.

Top module: `irq_enable_unit`

## Requirements
- R1: After reset the enable state is all zero (`ie_live` = 0), both base registers read zero, and `rd_data` and `access_fault` are 0.
- R2: The register index, and the return-jump register number, are taken from `insn[25:21]`; all other instruction bits have no effect.
- R3: A write to index 0 (enable state) replaces all three bits with `src_data[2:0]`: bit 0 live enable, bit 1 exception copy, bit 2 breakpoint copy. A read of index 0 returns them in those positions, with every higher bit zero.
- R4: `exc_enter` copies the live enable into the exception copy and clears the live enable; the breakpoint copy is kept.
- R5: `brk_enter` (without `exc_enter`) copies the live enable into the breakpoint copy and clears the live enable; the exception copy is kept.
- R6: `jump_ret` with register 30 loads the live enable from the exception copy.
- R7: `jump_ret` with register 31 loads the live enable from the breakpoint copy.
- R8: `jump_ret` with any other register leaves the enable state unchanged.
- R9: Same-cycle priority: `exc_enter`, then `brk_enter`, then an enable-state write, then a return jump. A lower event that loses is dropped.
- R10: Index 1 (exception base) and index 2 (debug base) store `src_data` with the low BASE_LSB bits (default 8) forced to zero, and read back the same way.
- R11: Indices 16..19 are breakpoint slots 0..3 and indices 20..23 are watchpoint slots 0..3. A write to slot n is legal when n < NUM_BP (or n < NUM_WP) and faults otherwise. Neither kind of write changes any readable state.
- R12: A read of an undefined index or of a breakpoint/watchpoint slot, and a write of an undefined index or of index 3, sets `access_fault`, returns zero data and changes no state.
- R13: Index 3 is read-only: bits 3:0 hold NUM_BP, bits 7:4 hold NUM_WP, and the rest are zero.
- R14: `rd_data` and `access_fault` are registered and answer the request of the previous cycle. `rd_data` is zero after any cycle with no legal read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn | input | 32 | Instruction word; bits 25:21 select the register |
| csr_rd | input | 1 | Read the indexed control register |
| csr_wr | input | 1 | Write `src_data` to the indexed control register |
| src_data | input | 32 | Write operand |
| jump_ret | input | 1 | A register-indirect jump is executed |
| exc_enter | input | 1 | Exception trap taken |
| brk_enter | input | 1 | Breakpoint trap taken |
| rd_data | output | 32 | Read data, one cycle after the request |
| ie_live | output | 1 | Current live interrupt enable |
| access_fault | output | 1 | Invalid access, one cycle after the request |

## Verification
Directed sequences first load asymmetric enable states, for example live set with only one copy set. With such a state, an exception return and a breakpoint return give different results, so a swapped copy cannot go unnoticed. Events are also paired in the same cycle to check that each higher-priority event wins. The build uses three breakpoint and two watchpoint slots, so slot writes just under and just over each count separate a legal write from an off-by-one limit. Seeded random streams then mix trap entries, return jumps through registers 28 to 31, noisy instruction bits and register accesses across the map; a bench-side model predicts every output.

// File: rtl/irq_en_pkg.sv
package irq_en_pkg;
  localparam int IDX_W = 5;
  localparam int IDX_LSB = 21;
  localparam int STATE_W = 3;
  localparam int BIT_LIVE = 0;
  localparam int BIT_EXC = 1;
  localparam int BIT_BRK = 2;

  localparam logic [IDX_W-1:0] CSR_STATE = 5'd0;
  localparam logic [IDX_W-1:0] CSR_XBASE = 5'd1;
  localparam logic [IDX_W-1:0] CSR_DBASE = 5'd2;
  localparam logic [IDX_W-1:0] CSR_CAPS  = 5'd3;
  localparam logic [2:0] GRP_BP = 3'b100;
  localparam logic [2:0] GRP_WP = 3'b101;

  typedef enum logic [2:0] {
    RS_NONE, RS_STATE, RS_XBASE, RS_DBASE, RS_CAPS
  } rsel_e;
endpackage

// File: rtl/irq_csr_dec.sv
module irq_csr_dec
  import irq_en_pkg::*;
#(
  parameter int NUM_BP = 4,
  parameter int NUM_WP = 4
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             rd,
  input  logic             wr,
  output logic             wr_state,
  output logic             wr_xbase,
  output logic             wr_dbase,
  output rsel_e            rsel,
  output logic             fault
);
  localparam int BP_MASK_I = (1 << NUM_BP) - 1;
  localparam int WP_MASK_I = (1 << NUM_WP) - 1;
  localparam logic [3:0] BP_MASK = BP_MASK_I[3:0];
  localparam logic [3:0] WP_MASK = WP_MASK_I[3:0];

  logic rd_ok, wr_ok;
  rsel_e sel_d;

  always_comb begin
    rd_ok = 1'b0;
    wr_ok = 1'b0;
    sel_d = RS_NONE;
    case (idx)
      CSR_STATE: begin rd_ok = 1'b1; wr_ok = 1'b1; sel_d = RS_STATE; end
      CSR_XBASE: begin rd_ok = 1'b1; wr_ok = 1'b1; sel_d = RS_XBASE; end
      CSR_DBASE: begin rd_ok = 1'b1; wr_ok = 1'b1; sel_d = RS_DBASE; end
      CSR_CAPS:  begin rd_ok = 1'b1; sel_d = RS_CAPS; end
      default: begin
        if (idx[4:2] == GRP_BP) wr_ok = BP_MASK[idx[1:0]];
        else if (idx[4:2] == GRP_WP) wr_ok = WP_MASK[idx[1:0]];
      end
    endcase
  end

  assign wr_state = wr && (idx == CSR_STATE);
  assign wr_xbase = wr && (idx == CSR_XBASE);
  assign wr_dbase = wr && (idx == CSR_DBASE);
  assign rsel     = (rd && rd_ok) ? sel_d : RS_NONE;
  assign fault    = (rd && !rd_ok) || (wr && !wr_ok);
endmodule

// File: rtl/irq_base_reg.sv
module irq_base_reg #(
  parameter int DATA_W   = 32,
  parameter int BASE_LSB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  generate
    if (BASE_LSB == 0) begin : g_full
      always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else if (we) q <= wdata;
      end
    end else begin : g_aligned
      logic [DATA_W-1:BASE_LSB] hi_q;
      logic unused_low;
      assign unused_low = ^wdata[BASE_LSB-1:0];
      always_ff @(posedge clk) begin
        if (!rst_n) hi_q <= '0;
        else if (we) hi_q <= wdata[DATA_W-1:BASE_LSB];
      end
      assign q = {hi_q, {BASE_LSB{1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/irq_en_state.sv
module irq_en_state
  import irq_en_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exc_enter,
  input  logic               brk_enter,
  input  logic               wr_state,
  input  logic [STATE_W-1:0] wdata,
  input  logic               ret_exc,
  input  logic               ret_brk,
  output logic [STATE_W-1:0] state_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= '0;
    end else if (exc_enter) begin
      state_q[BIT_EXC]  <= state_q[BIT_LIVE];
      state_q[BIT_LIVE] <= 1'b0;
    end else if (brk_enter) begin
      state_q[BIT_BRK]  <= state_q[BIT_LIVE];
      state_q[BIT_LIVE] <= 1'b0;
    end else if (wr_state) begin
      state_q <= wdata;
    end else if (ret_exc) begin
      state_q[BIT_LIVE] <= state_q[BIT_EXC];
    end else if (ret_brk) begin
      state_q[BIT_LIVE] <= state_q[BIT_BRK];
    end
  end
endmodule

// File: rtl/irq_enable_unit.sv
module irq_enable_unit
  import irq_en_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BASE_LSB = 8,
  parameter int NUM_BP = 4,
  parameter int NUM_WP = 4,
  parameter logic [4:0] EXC_RET_REG = 5'd30,
  parameter logic [4:0] BRK_RET_REG = 5'd31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       insn,
  input  logic              csr_rd,
  input  logic              csr_wr,
  input  logic [DATA_W-1:0] src_data,
  input  logic              jump_ret,
  input  logic              exc_enter,
  input  logic              brk_enter,
  output logic [DATA_W-1:0] rd_data,
  output logic              ie_live,
  output logic              access_fault
);
  logic [IDX_W-1:0] idx;
  logic unused_insn_bits;
  assign idx = insn[IDX_LSB +: IDX_W];
  assign unused_insn_bits = ^{insn[31:IDX_LSB+IDX_W], insn[IDX_LSB-1:0]};

  logic wr_state, wr_xbase, wr_dbase, fault_d;
  rsel_e rsel;
  logic [STATE_W-1:0] ien_q;
  logic [DATA_W-1:0] xbase_q, dbase_q, rdata_d;

  irq_csr_dec #(.NUM_BP(NUM_BP), .NUM_WP(NUM_WP)) dec_i (
    .idx(idx), .rd(csr_rd), .wr(csr_wr),
    .wr_state(wr_state), .wr_xbase(wr_xbase), .wr_dbase(wr_dbase),
    .rsel(rsel), .fault(fault_d)
  );

  irq_en_state state_i (
    .clk(clk), .rst_n(rst_n),
    .exc_enter(exc_enter), .brk_enter(brk_enter),
    .wr_state(wr_state), .wdata(src_data[STATE_W-1:0]),
    .ret_exc(jump_ret && (idx == EXC_RET_REG)),
    .ret_brk(jump_ret && (idx == BRK_RET_REG)),
    .state_q(ien_q)
  );

  irq_base_reg #(.DATA_W(DATA_W), .BASE_LSB(BASE_LSB)) xbase_i (
    .clk(clk), .rst_n(rst_n), .we(wr_xbase), .wdata(src_data), .q(xbase_q)
  );
  irq_base_reg #(.DATA_W(DATA_W), .BASE_LSB(BASE_LSB)) dbase_i (
    .clk(clk), .rst_n(rst_n), .we(wr_dbase), .wdata(src_data), .q(dbase_q)
  );

  always_comb begin
    rdata_d = '0;
    case (rsel)
      RS_STATE: rdata_d[STATE_W-1:0] = ien_q;
      RS_XBASE: rdata_d = xbase_q;
      RS_DBASE: rdata_d = dbase_q;
      RS_CAPS: begin
        rdata_d[3:0] = 4'(NUM_BP);
        rdata_d[7:4] = 4'(NUM_WP);
      end
      default: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      access_fault <= 1'b0;
    end else begin
      rd_data <= rdata_d;
      access_fault <= fault_d;
    end
  end

  assign ie_live = ien_q[BIT_LIVE];
endmodule

// File: rtl/irq_enable_chk.sv
module irq_enable_chk
  import irq_en_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BASE_LSB = 8,
  parameter int NUM_BP = 4,
  parameter logic [4:0] EXC_RET_REG = 5'd30,
  parameter logic [4:0] BRK_RET_REG = 5'd31
) (
  input logic               clk,
  input logic               rst_n,
  input logic [IDX_W-1:0]   idx,
  input logic               csr_rd,
  input logic               csr_wr,
  input logic               jump_ret,
  input logic               exc_enter,
  input logic               brk_enter,
  input logic [DATA_W-1:0]  rd_data,
  input logic               ie_live,
  input logic               access_fault,
  input logic [STATE_W-1:0] ien_q
);
  localparam int BP_MASK_I = (1 << NUM_BP) - 1;
  localparam logic [3:0] BP_MASK = BP_MASK_I[3:0];

  logic quiet, is_ret;
  assign quiet  = !exc_enter && !brk_enter && !(csr_wr && idx == CSR_STATE);
  assign is_ret = jump_ret && (idx == EXC_RET_REG || idx == BRK_RET_REG);

  assert_exc_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    exc_enter |=> !ie_live && ien_q[BIT_EXC] == $past(ien_q[BIT_LIVE]));

  assert_brk_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_enter && brk_enter) |=> !ie_live && ien_q[BIT_BRK] == $past(ien_q[BIT_LIVE]));

  assert_exc_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && jump_ret && idx == EXC_RET_REG) |=> ie_live == $past(ien_q[BIT_EXC]));

  assert_brk_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && jump_ret && idx == BRK_RET_REG) |=> ie_live == $past(ien_q[BIT_BRK]));

  assert_other_jump_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !is_ret) |=> $stable(ien_q));

  assert_slot_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && idx[4:2] == GRP_BP && !BP_MASK[idx[1:0]]) |=> access_fault);

  assert_base_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rd && (idx == CSR_XBASE || idx == CSR_DBASE)) |=> rd_data[BASE_LSB-1:0] == '0);

  assert_idle_read_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_rd |=> rd_data == '0);
endmodule

bind irq_enable_unit irq_enable_chk #(
  .DATA_W(DATA_W), .BASE_LSB(BASE_LSB), .NUM_BP(NUM_BP),
  .EXC_RET_REG(EXC_RET_REG), .BRK_RET_REG(BRK_RET_REG)
) chk_i (
  .clk(clk), .rst_n(rst_n), .idx(insn[25:21]),
  .csr_rd(csr_rd), .csr_wr(csr_wr), .jump_ret(jump_ret),
  .exc_enter(exc_enter), .brk_enter(brk_enter),
  .rd_data(rd_data), .ie_live(ie_live), .access_fault(access_fault),
  .ien_q(ien_q)
);

// File: tb/irq_enable_unit_tb_top.sv
module irq_enable_unit_tb_top;
  localparam int TB_BP = 3;
  localparam int TB_WP = 2;
  localparam logic [31:0] LOW_MASK = 32'h0000_00FF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] insn = '0;
  logic csr_rd = 0, csr_wr = 0, jump_ret = 0, exc_enter = 0, brk_enter = 0;
  logic [31:0] src_data = '0;
  logic [31:0] rd_data;
  logic ie_live, access_fault;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic m_live = 0, m_exc = 0, m_brk = 0;
  logic [31:0] m_xbase = '0, m_dbase = '0;

  always #10 clk = ~clk;

  irq_enable_unit #(.NUM_BP(TB_BP), .NUM_WP(TB_WP)) dut_i (
    .clk(clk), .rst_n(rst_n), .insn(insn), .csr_rd(csr_rd), .csr_wr(csr_wr),
    .src_data(src_data), .jump_ret(jump_ret), .exc_enter(exc_enter),
    .brk_enter(brk_enter), .rd_data(rd_data), .ie_live(ie_live),
    .access_fault(access_fault)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit readable(logic [4:0] i);
    return i <= 5'd3;
  endfunction

  function automatic bit writable(logic [4:0] i);
    if (i <= 5'd2) return 1;
    if (i >= 5'd16 && i < 5'd16 + 5'(TB_BP)) return 1;
    if (i >= 5'd20 && i < 5'd20 + 5'(TB_WP)) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] model_read(logic [4:0] i);
    case (i)
      5'd0: return {29'd0, m_brk, m_exc, m_live};
      5'd1: return m_xbase;
      5'd2: return m_dbase;
      5'd3: return {24'd0, 4'(TB_WP), 4'(TB_BP)};
      default: return '0;
    endcase
  endfunction

  task automatic apply(string tag, logic [4:0] idx, bit rd, bit wr, bit jr,
                       bit ex, bit bk, logic [31:0] data, logic [31:0] noise);
    logic [31:0] e_rd;
    logic e_fault;
    insn = (noise & ~32'h03E0_0000) | ({27'd0, idx} << 21);
    csr_rd = rd; csr_wr = wr; jump_ret = jr; exc_enter = ex; brk_enter = bk;
    src_data = data;
    e_rd = (rd && readable(idx)) ? model_read(idx) : 32'd0;
    e_fault = (rd && !readable(idx)) || (wr && !writable(idx));
    if (ex) begin m_exc = m_live; m_live = 0; end
    else if (bk) begin m_brk = m_live; m_live = 0; end
    else if (wr && idx == 5'd0) begin m_live = data[0]; m_exc = data[1]; m_brk = data[2]; end
    else if (jr && idx == 5'd30) m_live = m_exc;
    else if (jr && idx == 5'd31) m_live = m_brk;
    if (wr && idx == 5'd1) m_xbase = data & ~LOW_MASK;
    if (wr && idx == 5'd2) m_dbase = data & ~LOW_MASK;
    @(posedge clk);
    #2;
    chk({tag, " ie_live"}, {31'd0, ie_live}, {31'd0, m_live});
    chk({tag, " rd_data"}, rd_data, e_rd);
    chk({tag, " fault"}, {31'd0, access_fault}, {31'd0, e_fault});
    csr_rd = 0; csr_wr = 0; jump_ret = 0; exc_enter = 0; brk_enter = 0;
  endtask

  task automatic rd_state(string tag);
    apply(tag, 5'd0, 1, 0, 0, 0, 0, $urandom, $urandom);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    chk("R1 reset ie_live", {31'd0, ie_live}, 32'd0);
    chk("R1 reset rd_data", rd_data, 32'd0);
    chk("R1 reset fault", {31'd0, access_fault}, 32'd0);
    apply("R1 xbase", 5'd1, 1, 0, 0, 0, 0, 0, 0);
    apply("R1 dbase", 5'd2, 1, 0, 0, 0, 0, 0, 0);
    rd_state("R1 state");

    apply("R2 noisy write", 5'd0, 0, 1, 0, 0, 0, 32'hFFFF_FFFD, 32'hFFFF_FFFF);
    apply("R3 read state", 5'd0, 1, 0, 0, 0, 0, 0, 32'hFC1F_FFFF);
    apply("R3 write 010", 5'd0, 0, 1, 0, 0, 0, 32'h0000_0002, $urandom);
    rd_state("R3 readback");

    apply("R3 set live", 5'd0, 0, 1, 0, 0, 0, 32'd1, $urandom);
    apply("R4 exc entry", 5'd7, 0, 0, 0, 1, 0, 0, $urandom);
    rd_state("R4 saved copy");
    apply("R6 exc return", 5'd30, 0, 0, 1, 0, 0, 0, $urandom);
    apply("R5 brk entry", 5'd4, 0, 0, 0, 0, 1, 0, $urandom);
    rd_state("R5 saved copy");
    apply("R3 asym", 5'd0, 0, 1, 0, 0, 0, 32'd4, $urandom);
    apply("R7 brk return", 5'd31, 0, 0, 1, 0, 0, 0, $urandom);
    apply("R3 asym2", 5'd0, 0, 1, 0, 0, 0, 32'd2, $urandom);
    apply("R6 exc return only exc copy", 5'd30, 0, 0, 1, 0, 0, 0, $urandom);
    apply("R3 zero live", 5'd0, 0, 1, 0, 0, 0, 32'd6, $urandom);
    apply("R8 jump r29", 5'd29, 0, 0, 1, 0, 0, 0, $urandom);
    apply("R8 jump r0", 5'd0, 0, 0, 1, 0, 0, 0, $urandom);
    rd_state("R8 state kept");

    apply("R3 live", 5'd0, 0, 1, 0, 0, 0, 32'd1, $urandom);
    apply("R9 exc over brk", 5'd0, 0, 0, 0, 1, 1, 0, $urandom);
    rd_state("R9 after exc+brk");
    apply("R9 exc over write", 5'd0, 0, 1, 0, 1, 0, 32'd7, $urandom);
    rd_state("R9 write dropped");
    apply("R9 jump r30", 5'd30, 0, 0, 1, 0, 0, 0, $urandom);
    apply("R9 brk over return", 5'd31, 0, 0, 1, 0, 1, 0, $urandom);
    rd_state("R9 after brk+ret");

    apply("R10 xbase write", 5'd1, 0, 1, 0, 0, 0, 32'h1234_56FF, $urandom);
    apply("R10 xbase read", 5'd1, 1, 0, 0, 0, 0, 0, $urandom);
    apply("R10 dbase write", 5'd2, 0, 1, 0, 0, 0, 32'hDEAD_BEEF, $urandom);
    apply("R10 dbase read", 5'd2, 1, 0, 0, 0, 0, 0, $urandom);

    apply("R11 bp0", 5'd16, 0, 1, 0, 0, 0, $urandom, $urandom);
    apply("R11 bp2", 5'd18, 0, 1, 0, 0, 0, $urandom, $urandom);
    apply("R11 bp3", 5'd19, 0, 1, 0, 0, 0, $urandom, $urandom);
    apply("R11 wp1", 5'd21, 0, 1, 0, 0, 0, $urandom, $urandom);
    apply("R11 wp2", 5'd22, 0, 1, 0, 0, 0, $urandom, $urandom);
    apply("R11 wp3", 5'd23, 0, 1, 0, 0, 0, $urandom, $urandom);
    rd_state("R11 state kept");
    apply("R11 xbase kept", 5'd1, 1, 0, 0, 0, 0, 0, $urandom);

    apply("R12 read bp", 5'd16, 1, 0, 0, 0, 0, 0, $urandom);
    apply("R12 write caps", 5'd3, 0, 1, 0, 0, 0, 32'hFFFF_FFFF, $urandom);
    apply("R12 read unknown", 5'd31, 1, 0, 0, 0, 0, 0, $urandom);
    apply("R12 write unknown", 5'd9, 0, 1, 0, 0, 0, 32'hFFFF_FFFF, $urandom);
    rd_state("R12 state kept");
    apply("R13 caps", 5'd3, 1, 0, 0, 0, 0, 0, $urandom);
    apply("R14 idle", 5'd0, 0, 0, 0, 0, 0, 0, $urandom);

    for (int n = 0; n < 3000; n++) begin
      logic [4:0] ri;
      int pick;
      pick = $urandom_range(0, 9);
      if (pick < 4) ri = 5'($urandom_range(0, 3));
      else if (pick < 6) ri = 5'($urandom_range(16, 23));
      else if (pick < 8) ri = 5'($urandom_range(28, 31));
      else ri = 5'($urandom);
      apply("R9 random", ri, ($urandom % 3) == 0, ($urandom % 3) == 0,
            ($urandom % 3) == 0, ($urandom % 10) == 0, ($urandom % 10) == 0,
            $urandom, $urandom);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule